// File: doc/BRIEF.md
# Eight-Channel DAC Update Controller

This block holds the digital codes for eight 12-bit DAC channels. A host writes one code word per channel through a simple register strobe. In immediate mode, each write moves the new code straight to that channel's active output. In simultaneous mode, writes only fill a per-channel holding buffer. All eight buffers are then copied to the outputs in one clock cycle, on a common event. That event is a write to the software-trigger offset, or a falling edge on an active-low external trigger pin when the hold bit is clear.

A separate command offset clears every buffer and every output to the lowest code. A reference-enable input forces the visible codes to zero without losing the stored values. Each output change raises a one-cycle update pulse, which the converters can use as their conversion strobe. Codes are offset binary: 0x000 is the lowest output, 0x800 is mid-scale and 0xFFF is full scale. The host write port is a plain strobe with no back-pressure, and it accepts one write every cycle. The mode, trigger and reference pins are plain level inputs.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset every buffer and every active code is 0x000, update_pulse is low and immediate mode applies.
- R2: A write with wr_addr = 2*k (k = 0..7, bit 0 clear, bit 4 clear) stores wr_data[11:0] into channel k's buffer; wr_data[15:12] are ignored.
- R3: With simul_hold low, a channel write changes that channel's active code in the cycle after the write, and leaves the other seven channels unchanged.
- R4: With simul_hold high, channel writes and external trigger edges change no active code and raise no update_pulse; a trigger edge seen while holding is discarded, not queued.
- R5: A write of any data to offset 0x12 copies all eight buffers to the active codes in one cycle, whatever the level of simul_hold.
- R6: With simul_hold low, a falling edge on ext_trig_n loads all eight buffers into the active codes on the third rising clock edge after the fall; a pin held low fires only once.
- R7: A write of any data to offset 0x13 sets every buffer and every active code to 0x000.
- R8: While ref_en is low every chan_code lane reads 0x000; the stored codes come back unchanged when ref_en returns high.
- R9: update_pulse is high for exactly the one cycle after each event that updates the active codes.
- R10: Writes to offsets that are odd, or that lie in 0x10, 0x11 or 0x14 to 0x1F, change no buffer and no active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | 5 | Host write byte offset |
| wr_data | input | 16 | Host write data; bits 11:0 carry the code |
| simul_hold | input | 1 | 1 = simultaneous mode, 0 = immediate mode |
| ext_trig_n | input | 1 | Asynchronous active-low external update trigger |
| ref_en | input | 1 | Reference enable; when low, all codes read zero |
| chan_code | output | 96 | Active codes; channel k is at bits [12k+11:12k] |
| update_pulse | output | 1 | One-cycle pulse marking an output update |

## Verification
Writes and software or reset commands show up on chan_code and update_pulse one clock after the cycle in which the strobe is sampled. An external fall shows up after three rising edges: two for synchronisation and one for the load. The bench drives inputs on the falling clock edge and reads outputs on the next falling edge, one half-period after the due rising edge. For the external trigger it also reads the falling edge just before the due edge, to show that the codes are still old there. In simultaneous mode, all eight lanes are compared in the cycle before the trigger takes effect and again in the cycle after. This shows that every lane moves together and that none moves early.

// File: rtl/dac_update_pkg.sv
package dac_update_pkg;
  localparam int NUM_CH   = 8;
  localparam int CODE_W   = 12;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam logic [ADDR_W-1:0] OFS_SW_TRIG = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_CLEAR   = 5'h13;
endpackage

// File: rtl/ext_trig_sync.sv
module ext_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];

  assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_sel,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              direct,
  input  logic              load_all,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] buf_q;
  logic [CODE_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else if (clr) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_sel) buf_q <= wr_code;
      if (wr_sel && direct) act_q <= wr_code;
      else if (load_all)    act_q <= buf_q;
    end
  end

  assign code_o = act_q;

  assert_load_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_all && !clr && !wr_sel) |=> (act_q == $past(buf_q)));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (act_q == '0 && buf_q == '0));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_update_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     simul_hold,
  input  logic                     ext_trig_n,
  input  logic                     ref_en,
  output logic [NUM_CH*CODE_W-1:0] chan_code,
  output logic                     update_pulse
);
  logic                     ext_fall;
  logic                     chan_wr;
  logic [CH_IDX_W-1:0]      chan_idx;
  logic                     sw_trig;
  logic                     clr_cmd;
  logic                     load_all;
  logic                     upd_q;
  logic [NUM_CH*CODE_W-1:0] act_flat;
  logic                     unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

  ext_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_trig_n), .fall(ext_fall)
  );

  assign chan_wr  = wr_en && !wr_addr[ADDR_W-1] && !wr_addr[0];
  assign chan_idx = wr_addr[CH_IDX_W:1];
  assign sw_trig  = wr_en && (wr_addr == OFS_SW_TRIG);
  assign clr_cmd  = wr_en && (wr_addr == OFS_CLEAR);
  assign load_all = sw_trig || (ext_fall && !simul_hold);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dac_chan #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr(clr_cmd),
      .wr_sel(chan_wr && (chan_idx == CH_IDX_W'(k))),
      .wr_code(wr_data[CODE_W-1:0]), .direct(!simul_hold),
      .load_all(load_all), .code_o(act_flat[k*CODE_W +: CODE_W])
    );
    assign chan_code[k*CODE_W +: CODE_W] = ref_en ? act_flat[k*CODE_W +: CODE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= clr_cmd || load_all || (chan_wr && !simul_hold);
  end
  assign update_pulse = upd_q;

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (simul_hold && !sw_trig && !clr_cmd) |=> $stable(act_flat));

  assert_change_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((act_flat != $past(act_flat)) -> update_pulse));

  assert_other_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_wr && !sw_trig && !clr_cmd && !ext_fall) |=> $stable(act_flat));
endmodule

// File: tb/test_dac_update_ctrl.sv
module test_dac_update_ctrl;
  localparam int NCH = 8;
  localparam int W   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic simul_hold = 1'b0;
  logic ext_trig_n = 1'b1;
  logic ref_en = 1'b1;
  logic [NCH*W-1:0] chan_code;
  logic update_pulse;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] exp_buf [NCH];
  logic [W-1:0] exp_act [NCH];

  always #4 clk = ~clk;

  dac_update_ctrl i_dac_update_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .simul_hold(simul_hold), .ext_trig_n(ext_trig_n), .ref_en(ref_en),
    .chan_code(chan_code), .update_pulse(update_pulse)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s update_pulse actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req, input bit zero);
    for (int k = 0; k < NCH; k++) begin
      logic [W-1:0] e;
      e = zero ? '0 : exp_act[k];
      compared++;
      if (chan_code[k*W +: W] !== e) begin
        mismatched++;
        $display("FAIL %s ch%0d actual=%h expected=%h", req, k, chan_code[k*W +: W], e);
      end
    end
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset_R1;
    for (int k = 0; k < NCH; k++) begin exp_buf[k] = '0; exp_act[k] = '0; end
    check_codes("R1", 1'b0);
    check_bit("R1", update_pulse, 1'b0);
  endtask

  task automatic t_immediate_R3;
    for (int k = 0; k < NCH; k++) begin
      host_wr(5'(2*k), 16'hF000 | 16'(k * 16'h0123 + 16'h011));
      exp_buf[k] = 12'(k * 12'h123 + 12'h011);
      exp_act[k] = exp_buf[k];
      check_codes("R3 R2", 1'b0);
      check_bit("R9", update_pulse, 1'b1);
    end
    @(negedge clk);
    check_bit("R9", update_pulse, 1'b0);
  endtask

  task automatic t_other_ofs_R10;
    host_wr(5'h03, 16'h0ABC);
    host_wr(5'h10, 16'h0ABC);
    host_wr(5'h11, 16'h0ABC);
    host_wr(5'h1F, 16'h0ABC);
    check_codes("R10", 1'b0);
    check_bit("R10", update_pulse, 1'b0);
    host_wr(5'h12, 16'h0000);
    check_codes("R10 buffers", 1'b0);
  endtask

  task automatic t_hold_sw_R5;
    simul_hold = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      host_wr(5'(2*k), 16'(12'hFFF - 12'(k)));
      exp_buf[k] = 12'hFFF - 12'(k);
      check_bit("R4", update_pulse, 1'b0);
    end
    ext_trig_n = 1'b0;
    repeat (5) @(negedge clk);
    check_codes("R4 held", 1'b0);
    check_bit("R4", update_pulse, 1'b0);
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);
    simul_hold = 1'b0;
    repeat (4) @(negedge clk);
    check_codes("R4 not queued", 1'b0);
    host_wr(5'h12, 16'h5A5A);
    for (int k = 0; k < NCH; k++) exp_act[k] = exp_buf[k];
    check_codes("R5", 1'b0);
    check_bit("R5", update_pulse, 1'b1);
  endtask

  task automatic t_ext_R6;
    simul_hold = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      host_wr(5'(2*k), 16'(12'h800 + 12'(k * 3)));
      exp_buf[k] = 12'h800 + 12'(k * 3);
    end
    simul_hold = 1'b0;
    @(negedge clk);
    ext_trig_n = 1'b0;
    repeat (2) @(negedge clk);
    check_codes("R6 early", 1'b0);
    @(negedge clk);
    for (int k = 0; k < NCH; k++) exp_act[k] = exp_buf[k];
    check_codes("R6", 1'b0);
    check_bit("R6", update_pulse, 1'b1);
    @(negedge clk);
    check_bit("R9", update_pulse, 1'b0);
    host_wr(5'h0, 16'h0111);
    exp_buf[0] = 12'h111; exp_act[0] = 12'h111;
    repeat (5) @(negedge clk);
    check_bit("R6 level", update_pulse, 1'b0);
    check_codes("R6 level", 1'b0);
    ext_trig_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ref_R8;
    ref_en = 1'b0;
    @(negedge clk);
    check_codes("R8 off", 1'b1);
    ref_en = 1'b1;
    @(negedge clk);
    check_codes("R8 on", 1'b0);
  endtask

  task automatic t_clear_R7;
    host_wr(5'h13, 16'hFFFF);
    for (int k = 0; k < NCH; k++) begin exp_buf[k] = '0; exp_act[k] = '0; end
    check_codes("R7", 1'b0);
    check_bit("R7", update_pulse, 1'b1);
    host_wr(5'h12, 16'h0);
    check_codes("R7 buffers", 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_immediate_R3();
        t_other_ofs_R10();
        t_hold_sw_R5();
        t_ext_R6();
        t_ref_R8();
        t_clear_R7();
      end
      begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule